// File: doc/BRIEF.md
# Write Beat Serializer

The block sits on the write path between a local-side master and the memory data pins. Each local write word, together with its active-high byte enables, arrives on a valid/ready handshake. The block turns it into two beats on a memory data lane that is half as wide as the word. Each beat carries an active-low data mask with one bit per byte.

The lower half of the word and its lower enables leave first, and the upper half follows on the next cycle. While the second beat is pending, ready is low, so the block takes at most one word every two cycles. A master that presents words back to back therefore gets an unbroken stream of memory beats. A byte with a cleared enable still drives its data onto the lane, and its mask bit tells the memory to skip it. When no beat is issued, all mask bits sit at 1.

Top module: `wbs_serializer`

## Requirements
- R1: While rst_ni is low, mem_beat_o is 0 and every bit of mem_dm_o is 1. After reset is released, ready_o is 1.
- R2: A word is taken on a rising edge where valid_i and ready_o are both 1. In the next cycle mem_beat_o is 1 and mem_dq_o carries bits [MEM_DW-1:0] of that word.
- R3: In the cycle after the first beat, mem_beat_o is 1 and mem_dq_o carries bits [LOCAL_DW-1:MEM_DW] of the same word.
- R4: On each beat, mask bit i is the inverse of the enable for byte i of that half. The first beat uses enable bit i and the second beat uses enable bit MEM_BW+i, where MEM_BW is the number of bytes per beat. An enable of 1 gives mask 0.
- R5: A byte whose enable is 0 still appears unchanged on mem_dq_o in its beat position.
- R6: ready_o is 0 in the cycle after a word is taken and returns to 1 the cycle after that. Words offered back to back yield beats in every cycle, with no idle gap.
- R7: In any cycle without a beat, mem_beat_o is 0 and all mask bits are 1.
- R8: A word offered while ready_o is 0 is not taken and produces no beats. Beats already in progress are unaffected by it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wdata_i | input | LOCAL_DW | Local write word |
| wbe_i | input | LOCAL_DW/8 | Local byte enables, 1 = write byte |
| valid_i | input | 1 | Local word valid |
| ready_o | output | 1 | Block can take a word this cycle |
| mem_dq_o | output | LOCAL_DW/2 | Memory data lane |
| mem_dm_o | output | LOCAL_DW/16 | Memory data mask, 1 = skip byte |
| mem_beat_o | output | 1 | Memory beat valid |

## Verification
The bench builds the block with its default LOCAL_DW of 32. This gives a 16-bit lane with two mask bits per beat, so the enable patterns 1100, 0110 and 1010 on the words 0x22334455, 0x667788AA and 0xBBCCDDEE can be driven exactly as listed. With only two mask bits per beat, every mix of set and cleared enables within a half is reached by the random words as well. These words are mixed with back-to-back runs, idle gaps and a word offered during the stall cycle.

// File: rtl/wbs_pkg.sv
`timescale 1ns/1ps
package wbs_pkg;
  typedef enum logic {PH_LOW = 1'b0, PH_HIGH = 1'b1} phase_e;
endpackage

// File: rtl/wbs_lane_split.sv
`timescale 1ns/1ps
module wbs_lane_split #(
  parameter int unsigned LOCAL_DW = 32
) (
  input  logic [LOCAL_DW-1:0]    word_i,
  input  logic [LOCAL_DW/8-1:0]  be_i,
  output logic [LOCAL_DW/2-1:0]  lo_dq_o,
  output logic [LOCAL_DW/2-1:0]  hi_dq_o,
  output logic [LOCAL_DW/16-1:0] lo_dm_o,
  output logic [LOCAL_DW/16-1:0] hi_dm_o
);
  localparam int unsigned MEM_DW = LOCAL_DW / 2;
  localparam int unsigned MEM_BW = MEM_DW / 8;

  assign lo_dq_o = word_i[MEM_DW-1:0];
  assign hi_dq_o = word_i[LOCAL_DW-1:MEM_DW];

  // enable high -> mask low, per byte
  for (genvar g = 0; g < MEM_BW; g++) begin : g_mask
    assign lo_dm_o[g] = ~be_i[g];
    assign hi_dm_o[g] = ~be_i[MEM_BW+g];
  end
endmodule

// File: rtl/wbs_beat_seq.sv
`timescale 1ns/1ps
module wbs_beat_seq
  import wbs_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic valid_i,
  output logic ready_o,
  output logic load_lo_o,
  output logic load_hi_o
);
  phase_e phase_q, phase_d;

  assign ready_o   = (phase_q == PH_LOW);
  assign load_lo_o = valid_i & ready_o;
  assign load_hi_o = (phase_q == PH_HIGH);

  always_comb begin
    phase_d = phase_q;
    if (load_lo_o)      phase_d = PH_HIGH;
    else if (load_hi_o) phase_d = PH_LOW;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) phase_q <= PH_LOW;
    else         phase_q <= phase_d;
  end
endmodule

// File: rtl/wbs_out_reg.sv
`timescale 1ns/1ps
module wbs_out_reg #(
  parameter int unsigned MEM_DW = 16
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                load_lo_i,
  input  logic                load_hi_i,
  input  logic [MEM_DW-1:0]   lo_dq_i,
  input  logic [MEM_DW-1:0]   hi_dq_i,
  input  logic [MEM_DW/8-1:0] lo_dm_i,
  input  logic [MEM_DW/8-1:0] hi_dm_i,
  output logic [MEM_DW-1:0]   dq_o,
  output logic [MEM_DW/8-1:0] dm_o,
  output logic                beat_o
);
  localparam int unsigned MEM_BW = MEM_DW / 8;

  logic [MEM_DW-1:0] hold_dq_q;
  logic [MEM_BW-1:0] hold_dm_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dq_o      <= '0;
      dm_o      <= '1;
      beat_o    <= 1'b0;
      hold_dq_q <= '0;
      hold_dm_q <= '1;
    end else if (load_lo_i) begin
      dq_o      <= lo_dq_i;
      dm_o      <= lo_dm_i;
      beat_o    <= 1'b1;
      hold_dq_q <= hi_dq_i;
      hold_dm_q <= hi_dm_i;
    end else if (load_hi_i) begin
      dq_o   <= hold_dq_q;
      dm_o   <= hold_dm_q;
      beat_o <= 1'b1;
    end else begin
      dm_o   <= '1;   // idle: keep memory from writing
      beat_o <= 1'b0;
    end
  end
endmodule

// File: rtl/wbs_serializer.sv
`timescale 1ns/1ps
module wbs_serializer #(
  parameter int unsigned LOCAL_DW = 32
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic [LOCAL_DW-1:0]    wdata_i,
  input  logic [LOCAL_DW/8-1:0]  wbe_i,
  input  logic                   valid_i,
  output logic                   ready_o,
  output logic [LOCAL_DW/2-1:0]  mem_dq_o,
  output logic [LOCAL_DW/16-1:0] mem_dm_o,
  output logic                   mem_beat_o
);
  localparam int unsigned MEM_DW = LOCAL_DW / 2;
  localparam int unsigned MEM_BW = MEM_DW / 8;

  logic [MEM_DW-1:0] lo_dq, hi_dq;
  logic [MEM_BW-1:0] lo_dm, hi_dm;
  logic              load_lo, load_hi;

  wbs_lane_split #(.LOCAL_DW(LOCAL_DW)) u_split (
    .word_i (wdata_i),
    .be_i   (wbe_i),
    .lo_dq_o(lo_dq),
    .hi_dq_o(hi_dq),
    .lo_dm_o(lo_dm),
    .hi_dm_o(hi_dm)
  );

  wbs_beat_seq u_seq (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .valid_i  (valid_i),
    .ready_o  (ready_o),
    .load_lo_o(load_lo),
    .load_hi_o(load_hi)
  );

  wbs_out_reg #(.MEM_DW(MEM_DW)) u_out (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .load_lo_i(load_lo),
    .load_hi_i(load_hi),
    .lo_dq_i  (lo_dq),
    .hi_dq_i  (hi_dq),
    .lo_dm_i  (lo_dm),
    .hi_dm_i  (hi_dm),
    .dq_o     (mem_dq_o),
    .dm_o     (mem_dm_o),
    .beat_o   (mem_beat_o)
  );
endmodule

// File: rtl/wbs_serializer_chk.sv
`timescale 1ns/1ps
module wbs_serializer_chk #(
  parameter int unsigned LOCAL_DW = 32
) (
  input logic                   clk_i,
  input logic                   rst_ni,
  input logic [LOCAL_DW-1:0]    wdata_i,
  input logic [LOCAL_DW/8-1:0]  wbe_i,
  input logic                   valid_i,
  input logic                   ready_o,
  input logic [LOCAL_DW/2-1:0]  mem_dq_o,
  input logic [LOCAL_DW/16-1:0] mem_dm_o,
  input logic                   mem_beat_o
);
  localparam int unsigned MEM_DW = LOCAL_DW / 2;
  localparam int unsigned MEM_BW = MEM_DW / 8;

  AST_ACCEPT_DROPS_READY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && ready_o |=> !ready_o); // R6
  AST_READY_RETURNS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ready_o |=> ready_o); // R6
  AST_FIRST_BEAT_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && ready_o |=> mem_beat_o && mem_dq_o == $past(wdata_i[MEM_DW-1:0])); // R2
  AST_FIRST_MASK_INV: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && ready_o |=> mem_dm_o == ~$past(wbe_i[MEM_BW-1:0])); // R4
  AST_SECOND_BEAT_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ready_o |=> mem_beat_o && mem_dq_o == $past(wdata_i[LOCAL_DW-1:MEM_DW], 2)); // R3
  AST_IDLE_MASKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mem_beat_o |-> &mem_dm_o); // R7
endmodule

bind wbs_serializer wbs_serializer_chk #(.LOCAL_DW(LOCAL_DW)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .wdata_i   (wdata_i),
  .wbe_i     (wbe_i),
  .valid_i   (valid_i),
  .ready_o   (ready_o),
  .mem_dq_o  (mem_dq_o),
  .mem_dm_o  (mem_dm_o),
  .mem_beat_o(mem_beat_o)
);

// File: tb/wbs_serializer_bench.sv
`timescale 1ns/1ps
module wbs_serializer_bench;
  localparam int LW = 32;
  localparam int MW = LW / 2;
  localparam int MB = MW / 8;

  typedef struct {
    logic [MW-1:0] dq;
    logic [MB-1:0] dm;
    bit            second;
    bit            partial;
  } beat_t;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [LW-1:0] wdata = '0;
  logic [LW/8-1:0] wbe = '0;
  logic          valid = 1'b0;
  logic          ready;
  logic [MW-1:0] dq;
  logic [MB-1:0] dm;
  logic          beat;

  int n_chk = 0;
  int n_fail = 0;
  int cycles = 0;
  bit done = 1'b0;

  beat_t q[$];
  beat_t exp_b;
  bit    exp_beat = 1'b0;
  bit    exp_ready = 1'b1;

  always #2 clk = ~clk;

  wbs_serializer #(.LOCAL_DW(LW)) u_wbs_serializer (
    .clk_i(clk), .rst_ni(rst_n), .wdata_i(wdata), .wbe_i(wbe), .valid_i(valid),
    .ready_o(ready), .mem_dq_o(dq), .mem_dm_o(dm), .mem_beat_o(beat)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  // reference: each taken word queues two beats, one beat leaves per cycle
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q.delete();
      exp_beat  = 1'b0;
      exp_ready = 1'b1;
    end else begin
      if (valid && exp_ready) begin
        beat_t b;
        b.dq = wdata[MW-1:0];  b.dm = ~wbe[MB-1:0];   b.second = 1'b0; b.partial = !(&wbe[MB-1:0]);
        q.push_back(b);
        b.dq = wdata[LW-1:MW]; b.dm = ~wbe[LW/8-1:MB]; b.second = 1'b1; b.partial = !(&wbe[LW/8-1:MB]);
        q.push_back(b);
      end
      if (q.size() > 0) begin
        exp_b    = q.pop_front();
        exp_beat = 1'b1;
      end else begin
        exp_beat = 1'b0;
      end
      exp_ready = (q.size() == 0);
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk(ready == exp_ready, "R6 ready", 32'(ready), 32'(exp_ready));
      chk(beat == exp_beat, "R2 beat", 32'(beat), 32'(exp_beat));
      if (exp_beat) begin
        chk(dm == exp_b.dm, "R4 mask", 32'(dm), 32'(exp_b.dm));
        chk(dq == exp_b.dq, exp_b.partial ? "R5 data" : (exp_b.second ? "R3 data" : "R2 data"),
            32'(dq), 32'(exp_b.dq));
      end else begin
        chk(&dm, "R7 idle mask", 32'(dm), {32{1'b1}});
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !done) begin
      done = 1'b1;
      n_fail++;
      $display("FAIL watchdog act=%0d exp=%0d", cycles, 100000);
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

  task automatic send(input logic [LW-1:0] d, input logic [LW/8-1:0] b, input int gap);
    bit took;
    valid = 1'b1; wdata = d; wbe = b;
    do begin took = exp_ready; @(negedge clk); end while (!took);
    valid = 1'b0; wdata = $urandom; wbe = 4'($urandom);
    repeat (gap) @(negedge clk);
  endtask

  initial begin
    // R1: reset holds beats off with garbage offered
    valid = 1'b1; wdata = 32'hDEADBEEF; wbe = 4'hF;
    repeat (3) begin
      @(negedge clk);
      chk(beat == 1'b0, "R1 reset beat", 32'(beat), 0);
      chk(&dm, "R1 reset mask", 32'(dm), {32{1'b1}});
    end
    valid = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(ready == 1'b1, "R1 ready after reset", 32'(ready), 1);

    // R2 R3 R4: the three example words back to back
    send(32'h22334455, 4'b1100, 0);
    send(32'h667788AA, 4'b0110, 0);
    send(32'hBBCCDDEE, 4'b1010, 3);

    // R5: fully masked word still drives data
    send(32'hCAFEF00D, 4'b0000, 2);

    // R8: word offered during stall is not taken
    valid = 1'b1; wdata = 32'h13579BDF; wbe = 4'hF;
    @(negedge clk);
    wdata = 32'h2468ACE0; wbe = 4'h5;
    chk(ready == 1'b0, "R8 stall ready", 32'(ready), 0);
    @(negedge clk);
    valid = 1'b0;
    chk(beat && dq == 16'h1357, "R8 second beat kept", 32'(dq), 32'h1357);
    @(negedge clk);
    chk(beat == 1'b0, "R8 no extra beat", 32'(beat), 0);
    repeat (2) @(negedge clk);

    // R6: long back-to-back run, then random gaps
    for (int i = 0; i < 200; i++) send($urandom, 4'($urandom), 0);
    for (int i = 0; i < 300; i++) send($urandom, 4'($urandom), int'($urandom % 3));
    repeat (4) @(negedge clk);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule